// File: doc/BRIEF.md
# Supervisor Mode Guard with Job Time Limit

This block watches a processor on behalf of a resident supervisor program in a simple batch system. It keeps one bit of state that says whether the processor is running supervisor code (privileged) or a user job. While a job runs, the block does three things. It compares every write address against a protected window that holds the supervisor's memory. It counts down the time the job has left. It flags any privileged instruction, such as an I/O operation, that the job tries to execute.

Any of these events raises a one-cycle trap with a two-bit reason code. The trap also puts the processor back in supervisor mode. A write into the protected window is blocked in the same cycle it shows up on the bus, so it never reaches memory. The supervisor starts a job with a strobe that switches to user mode and loads the time limit. A job can also return control on its own with a second strobe, which does not raise a trap. All pins are plain control and status signals. The block has no data stream, so no valid/ready handshake or back-pressure applies.

Top module: `mon_guard`

## Requirements
- R1: After reset the block is in supervisor mode (`user_mode_o`=0), `trap_o`=0, `cause_o`=00 and `wr_inhibit_o`=0.
- R2: A `go_user_i` pulse in supervisor mode sets `user_mode_o` to 1 on the next cycle and loads the time limit from `time_limit_i`. A `go_user_i` pulse in user mode is ignored and does not reload the limit.
- R3: In user mode, `wr_inhibit_o` is high in the same cycle as a write (`bus_wr_i`=1) whose address meets `win_base_i` ≤ `bus_addr_i` < `win_limit_i`. Addresses `win_base_i`-1 and `win_limit_i` are not blocked.
- R4: A blocked write gives `trap_o`=1 with `cause_o`=01 in the next cycle, and `user_mode_o` is 0 in that cycle.
- R5: In user mode, an instruction with `instr_valid_i`=1 and `instr_priv_i`=1 gives a trap with `cause_o`=11 in the next cycle and returns to supervisor mode.
- R6: With time limit N loaded, a job that raises no other event gets exactly N+1 user-mode cycles. A trap with `cause_o`=10 follows in the next cycle.
- R7: In supervisor mode, writes into the protected window are not blocked, and privileged instructions cause no trap.
- R8: When several events occur in one cycle, the reported cause follows this priority: memory (01) first, then privilege (11), then timer (10). `trap_o` is high for exactly one cycle per trap.
- R9: The timer stops outside user mode, so no timer trap can occur in supervisor mode. Each entry to user mode reloads the limit.
- R10: A `go_sup_i` pulse in user mode with no event in the same cycle returns the block to supervisor mode on the next cycle without a trap. If an event occurs in the same cycle, the trap is reported.
- R11: `cause_o` keeps its value from the most recent trap until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_user_i | input | 1 | Supervisor strobe to start a user job |
| go_sup_i | input | 1 | User strobe to return control voluntarily |
| time_limit_i | input | TW | Time limit loaded on entry to user mode |
| win_base_i | input | AW | First protected address |
| win_limit_i | input | AW | First address past the protected window |
| bus_addr_i | input | AW | Processor bus address |
| bus_wr_i | input | 1 | Processor write strobe |
| instr_valid_i | input | 1 | An instruction executes this cycle |
| instr_priv_i | input | 1 | That instruction is privileged |
| wr_inhibit_o | output | 1 | Blocks the current write (combinational) |
| trap_o | output | 1 | One-cycle trap request |
| cause_o | output | 2 | Trap reason: 01 memory, 10 timer, 11 privilege |
| user_mode_o | output | 1 | 1 while a user job runs |

## Verification
The bench probes both edges of the protected window. A comparison off by one, such as using ≤ on the limit, would block address `win_limit_i` or miss `win_base_i`. It counts the user cycles up to expiry for limits of 0 and above, which catches a timer that expires one cycle early or late. It also pulses `go_user_i` in the middle of a job to catch a design that reloads the limit while the job is running. Cycles with more than one event show whether the priority is wrong. Long stretches in supervisor mode after a trap would expose a timer that keeps running and fires in the wrong mode.

// File: rtl/mon_guard_pkg.sv
package mon_guard_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_MEM   = 2'b01,
    CAUSE_TIMER = 2'b10,
    CAUSE_PRIV  = 2'b11
  } cause_e;
endpackage

// File: rtl/mg_window_cmp.sv
module mg_window_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  // half-open window: base inclusive, limit exclusive
  assign hit_o = (addr_i >= base_i) && (addr_i < limit_i);
endmodule

// File: rtl/mg_job_timer.sv
module mg_job_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          run_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (load_i)                    cnt_q <= load_val_i;
    else if (run_i && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
  end

  // the count is frozen whenever the job is not running
  assign expire_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/mg_mode_ctrl.sv
module mg_mode_ctrl
  import mon_guard_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go_user_i,
  input  logic   go_sup_i,
  input  logic   mem_ev_i,
  input  logic   priv_ev_i,
  input  logic   tmr_ev_i,
  output logic   user_mode_o,
  output logic   enter_o,
  output logic   trap_o,
  output cause_e cause_o
);
  logic   any_ev;
  cause_e ev_cause;

  assign any_ev  = mem_ev_i || priv_ev_i || tmr_ev_i;
  assign enter_o = !user_mode_o && go_user_i;

  always_comb begin
    if (mem_ev_i)       ev_cause = CAUSE_MEM;
    else if (priv_ev_i) ev_cause = CAUSE_PRIV;
    else                ev_cause = CAUSE_TIMER;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_mode_o <= 1'b0;
      trap_o      <= 1'b0;
      cause_o     <= CAUSE_NONE;
    end else begin
      trap_o <= 1'b0;
      if (user_mode_o) begin
        if (any_ev) begin
          trap_o      <= 1'b1;
          cause_o     <= ev_cause;
          user_mode_o <= 1'b0;
        end else if (go_sup_i) begin
          user_mode_o <= 1'b0;
        end
      end else if (go_user_i) begin
        user_mode_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mon_guard.sv
module mon_guard
  import mon_guard_pkg::*;
#(
  parameter int AW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_user_i,
  input  logic          go_sup_i,
  input  logic [TW-1:0] time_limit_i,
  input  logic [AW-1:0] win_base_i,
  input  logic [AW-1:0] win_limit_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          instr_valid_i,
  input  logic          instr_priv_i,
  output logic          wr_inhibit_o,
  output logic          trap_o,
  output logic [1:0]    cause_o,
  output logic          user_mode_o
);
  logic   in_win, mem_ev, priv_ev, tmr_ev, enter;
  cause_e cause;

  mg_window_cmp #(.AW(AW)) u_win (
    .base_i (win_base_i),
    .limit_i(win_limit_i),
    .addr_i (bus_addr_i),
    .hit_o  (in_win)
  );

  assign mem_ev  = user_mode_o && bus_wr_i && in_win;
  assign priv_ev = user_mode_o && instr_valid_i && instr_priv_i;

  mg_job_timer #(.TW(TW)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (enter),
    .load_val_i(time_limit_i),
    .run_i     (user_mode_o),
    .expire_o  (tmr_ev)
  );

  mg_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_user_i  (go_user_i),
    .go_sup_i   (go_sup_i),
    .mem_ev_i   (mem_ev),
    .priv_ev_i  (priv_ev),
    .tmr_ev_i   (tmr_ev),
    .user_mode_o(user_mode_o),
    .enter_o    (enter),
    .trap_o     (trap_o),
    .cause_o    (cause)
  );

  assign wr_inhibit_o = mem_ev;
  assign cause_o      = cause;
endmodule

// File: rtl/mon_guard_chk.sv
module mon_guard_chk #(
  parameter int AW = 16,
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go_user_i,
  input logic          go_sup_i,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_wr_i,
  input logic          instr_valid_i,
  input logic          instr_priv_i,
  input logic          wr_inhibit_o,
  input logic          trap_o,
  input logic [1:0]    cause_o,
  input logic          user_mode_o
);
  // R3
  inhibit_needs_user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit_o |-> (user_mode_o && bus_wr_i));
  // R7
  no_inhibit_in_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode_o |-> !wr_inhibit_o);
  // R4
  mem_trap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit_o |=> (trap_o && cause_o == 2'b01 && !user_mode_o));
  // R5
  priv_trap_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode_o && instr_valid_i && instr_priv_i && !wr_inhibit_o) |=> (trap_o && cause_o == 2'b11));
  // R8
  trap_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> !trap_o);
  // R11
  cause_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |-> $stable(cause_o));
  // R2
  enter_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode_o && go_user_i) |=> user_mode_o);
  // R10
  leave_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode_o && go_sup_i) |=> !user_mode_o);
  // R9
  trap_only_from_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(user_mode_o) && !user_mode_o));
endmodule

bind mon_guard mon_guard_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_user_i(go_user_i), .go_sup_i(go_sup_i),
  .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .instr_valid_i(instr_valid_i),
  .instr_priv_i(instr_priv_i), .wr_inhibit_o(wr_inhibit_o), .trap_o(trap_o),
  .cause_o(cause_o), .user_mode_o(user_mode_o)
);

// File: tb/tb_mon_guard.sv
`timescale 1ns/1ps
module tb_mon_guard;
  localparam int AW = 16;
  localparam int TW = 16;
  localparam logic [AW-1:0] BASE  = 16'h0100;
  localparam logic [AW-1:0] LIMIT = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go_user_i = 0, go_sup_i = 0, bus_wr_i = 0, instr_valid_i = 0, instr_priv_i = 0;
  logic [TW-1:0] time_limit_i = '0;
  logic [AW-1:0] bus_addr_i = '0;
  logic wr_inhibit_o, trap_o, user_mode_o;
  logic [1:0] cause_o;

  int checks = 0, failures = 0;
  int m_user = 0, m_cnt = 0, m_trap = 0, m_cause = 0;
  int cyc;

  always #2 clk = ~clk;

  mon_guard #(.AW(AW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .go_user_i(go_user_i), .go_sup_i(go_sup_i),
    .time_limit_i(time_limit_i), .win_base_i(BASE), .win_limit_i(LIMIT),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .instr_valid_i(instr_valid_i),
    .instr_priv_i(instr_priv_i), .wr_inhibit_o(wr_inhibit_o), .trap_o(trap_o),
    .cause_o(cause_o), .user_mode_o(user_mode_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle; inputs change after the falling edge
  task automatic step(input string tag, input bit gu, input bit gs, input int addr,
                      input bit wr, input bit iv, input bit ip, input int lim);
    int viol, priv, expd;
    @(negedge clk);
    go_user_i = gu; go_sup_i = gs; bus_addr_i = addr[AW-1:0]; bus_wr_i = wr;
    instr_valid_i = iv; instr_priv_i = ip; time_limit_i = lim[TW-1:0];
    #1;
    viol = (m_user && wr && addr >= int'(BASE) && addr < int'(LIMIT)) ? 1 : 0;
    chk(tag, "wr_inhibit", int'(wr_inhibit_o), viol);
    priv = (m_user && iv && ip) ? 1 : 0;
    expd = (m_user && m_cnt == 0) ? 1 : 0;
    @(posedge clk);
    m_trap = 0;
    if (m_user) begin
      if (viol || priv || expd) begin
        m_trap = 1; m_user = 0;
        m_cause = viol ? 1 : (priv ? 3 : 2);
      end else if (gs) m_user = 0;
      else m_cnt--;
    end else if (gu) begin
      m_user = 1; m_cnt = lim;
    end
    #1;
    chk(tag, "trap", int'(trap_o), m_trap);
    chk(tag, "cause", int'(cause_o), m_cause);
    chk(tag, "user_mode", int'(user_mode_o), m_user);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "user_mode", int'(user_mode_o), 0);
    chk("R1", "trap", int'(trap_o), 0);
    chk("R1", "cause", int'(cause_o), 0);
    chk("R1", "wr_inhibit", int'(wr_inhibit_o), 0);
    @(negedge clk); rst_n = 1;

    // R7: supervisor may write the window and run privileged code
    step("R7", 0, 0, 'h150, 1, 0, 0, 0);
    step("R7", 0, 0, 'h100, 1, 1, 1, 0);
    idle("R9", 5);

    // R3 window edges, then R4 violation
    step("R2", 1, 0, 0, 0, 0, 0, 40);
    step("R3", 0, 0, 'h0FF, 1, 0, 0, 0);
    step("R3", 0, 0, 'h200, 1, 0, 0, 0);
    step("R3", 0, 0, 'h100, 0, 0, 0, 0);
    step("R4", 0, 0, 'h100, 1, 0, 0, 0);
    idle("R11", 3);

    step("R2", 1, 0, 0, 0, 0, 0, 40);
    step("R3", 0, 0, 'h1FF, 1, 0, 0, 0);
    idle("R11", 2);

    // R5 privileged instruction
    step("R2", 1, 0, 0, 0, 0, 0, 40);
    step("R5", 0, 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 1, 0);
    idle("R9", 4);

    // R6 timer expiry for several limits; R2 mid-job strobe ignored
    step("R2", 1, 0, 0, 0, 0, 0, 5);
    idle("R6", 2);
    step("R2", 1, 0, 0, 0, 0, 0, 30);
    idle("R6", 6);
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    idle("R6", 2);
    step("R2", 1, 0, 0, 0, 0, 0, 1);
    idle("R6", 3);

    // R8 priority
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 'h180, 1, 1, 1, 0);
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 'h180, 1, 0, 0, 0);
    step("R2", 1, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 1, 0);
    idle("R9", 40);

    // R10 voluntary return, then a stale timer must not fire
    step("R2", 1, 0, 0, 0, 0, 0, 2);
    step("R10", 0, 1, 0, 0, 0, 0, 0);
    idle("R9", 10);
    step("R2", 1, 0, 0, 0, 0, 0, 3);
    step("R10", 0, 1, 'h120, 1, 0, 0, 0);
    idle("R11", 3);

    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step("R8", (r < 8), (r > 96), $urandom_range('h0F0, 'h210),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 19) == 0), $urandom_range(0, 25));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule